// File: doc/BRIEF.md
# Configurable Four-Macrocell Logic Block

This block is the programmable logic cell of a small programmable logic fabric. Eighteen routed signals enter an array of product terms, each term an AND over any mix of true and inverted inputs. Four macrocells combine these terms into four outputs. A macrocell either takes a short path, which ORs the four terms it owns, or a wide path, which ORs any subset of the twenty logic terms and can XOR the result with its first owned term. Each macrocell output is either the combined sum directly or a flip-flop holding that sum.

The flip-flops share one block clock. The clock is one of three global clocks or a clock built from a dedicated product term. An active-low global clear and an optional dedicated reset term both clear the flip-flops asynchronously, and a further dedicated term can drive the common output enable. All settings are loaded one word at a time through a parallel write port clocked by `clk`. Registered feedback, as in a counter, leaves the block and returns through the routing inputs.

Top module: `glb_logic_block`

## Requirements
- R1: A product term is 1 when, for every input i, stored bit i (true use) set implies input i is 1 and stored bit 18+i (inverted use) set implies input i is 0. So an all-zero row gives 1, and a row with both bits of one input set gives 0.
- R2: With its bypass bit set, output k is the OR of logic terms 4k to 4k+3 and nothing else.
- R3: With bypass clear, output k is the OR of the logic terms selected by its 20-bit mask, XORed with term 4k when its XOR bit is set.
- R4: A macrocell with its registered bit clear follows its sum with no clock. With the bit set, it shows a flip-flop that changes only on a rising edge of the block clock.
- R5: Clock select value 0, 1 or 2 picks global clock 0, 1 or 2. Value 3 picks product term row 22. Edges on unselected clocks have no effect.
- R6: While gclr_n is low, every flip-flop reads 0 at once, and a clock edge cannot load it.
- R7: When the reset-term enable is set, term row 20 clears the flip-flops at once and overrides clock edges. When the enable is clear, that term has no effect.
- R8: When the output-enable-term flag is set, all four bits of dout_oe equal term row 21. Otherwise dout_oe is 4'b1111.
- R9: With cfg_we high at a rising clk edge, the word at cfg_addr is loaded. Addresses 0..22 are term rows (bits 17:0 true use, 35:18 inverted use). Addresses 23..26 are macrocell 0..3 settings (bit 22 registered, bit 21 bypass, bit 20 XOR, bits 19:0 mask). Address 27 holds block settings (bits 1:0 clock select, bit 2 reset-term enable, bit 3 output-enable-term flag). rst clears every setting, which gives dout = 0 and dout_oe = 4'b1111.
- R10: With cfg_we low, no setting changes, whatever cfg_addr and cfg_wdata carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration write clock |
| rst | input | 1 | Synchronous active-high clear of all settings |
| cfg_we | input | 1 | Write strobe for one setting word |
| cfg_addr | input | 5 | Setting word address |
| cfg_wdata | input | 36 | Setting word data |
| gclk | input | 3 | Global clocks available to the block |
| gclr_n | input | 1 | Active-low asynchronous clear of all flip-flops |
| din | input | 18 | Routed logic inputs |
| dout | output | 4 | Macrocell outputs |
| dout_oe | output | 4 | Output enables |

## Verification
A clear and a rising edge of the selected block clock can arrive together. Either the global clear or the reset term can take that role, and the clear must win. The bench builds a 4-bit counter whose outputs feed back into the inputs. It then holds each clear source active while it pulses the selected clock. The outputs must stay at zero during that time. After release, counting must resume from one, which shows that no edge was taken while the clear was held.

// File: rtl/glb_pkg.sv
`timescale 1ns/1ps
package glb_pkg;
    localparam int NUM_IN      = 18;
    localparam int NUM_PT      = 20;
    localparam int NUM_MC      = 4;
    localparam int PT_PER_MC   = 4;
    localparam int NUM_GCLK    = 3;
    localparam int ROW_W       = 2 * NUM_IN;
    localparam int ROW_RST     = NUM_PT;
    localparam int ROW_OE      = NUM_PT + 1;
    localparam int ROW_CLK     = NUM_PT + 2;
    localparam int NUM_PT_ROWS = NUM_PT + 3;
    localparam int ADDR_MC0    = NUM_PT_ROWS;
    localparam int ADDR_BLK    = ADDR_MC0 + NUM_MC;
    localparam int NUM_ADDR    = ADDR_BLK + 1;
    localparam int ADDR_W      = $clog2(NUM_ADDR);

    typedef enum logic [1:0] {CK_G0, CK_G1, CK_G2, CK_PT} clk_sel_e;

    typedef struct packed {
        logic              registered;
        logic              bypass;
        logic              xor_en;
        logic [NUM_PT-1:0] or_mask;
    } mc_cfg_t;
    localparam int MC_W = $bits(mc_cfg_t);

    typedef struct packed {
        logic     oe_pt_en;
        logic     rst_pt_en;
        clk_sel_e clk_sel;
    } blk_cfg_t;
    localparam int BLK_W = $bits(blk_cfg_t);

    typedef logic [ROW_W-1:0] pt_row_t;

    // AND of the selected literals; an empty row is true.
    function automatic logic pt_eval(pt_row_t row, logic [NUM_IN-1:0] x);
        logic hit;
        hit = 1'b1;
        for (int i = 0; i < NUM_IN; i++) begin
            if (row[i] && !x[i])          hit = 1'b0;
            if (row[NUM_IN + i] && x[i])  hit = 1'b0;
        end
        return hit;
    endfunction
endpackage

// File: rtl/glb_cfg_store.sv
`timescale 1ns/1ps
module glb_cfg_store
    import glb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  wdata,
    output pt_row_t           rows   [NUM_PT_ROWS],
    output mc_cfg_t           mc_cfg [NUM_MC],
    output blk_cfg_t          blk_cfg
);
    for (genvar g = 0; g < NUM_PT_ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                rows[g] <= '0;
            else if (we && addr == ADDR_W'(g))
                rows[g] <= wdata;
        end
    end

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        always_ff @(posedge clk) begin
            if (rst)
                mc_cfg[m] <= '0;
            else if (we && addr == ADDR_W'(ADDR_MC0 + m))
                mc_cfg[m] <= mc_cfg_t'(wdata[MC_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            blk_cfg <= '0;
        else if (we && addr == ADDR_W'(ADDR_BLK))
            blk_cfg <= blk_cfg_t'(wdata[BLK_W-1:0]);
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(we && !rst && addr == ADDR_W'(ADDR_BLK)) |->
            (blk_cfg == blk_cfg_t'($past(wdata[BLK_W-1:0])))) else $error("cfg write lost"); // R9

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(blk_cfg) && $stable(mc_cfg[0]))) else $error("cfg changed without write"); // R10
endmodule

// File: rtl/glb_and_plane.sv
`timescale 1ns/1ps
module glb_and_plane
    import glb_pkg::*;
(
    input  logic [NUM_IN-1:0]      din,
    input  pt_row_t                rows [NUM_PT_ROWS],
    output logic [NUM_PT_ROWS-1:0] pt
);
    for (genvar g = 0; g < NUM_PT_ROWS; g++) begin : g_term
        assign pt[g] = pt_eval(rows[g], din);
    end
endmodule

// File: rtl/glb_macrocell.sv
`timescale 1ns/1ps
module glb_macrocell
    import glb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              blk_clk,
    input  logic              clr,
    input  logic [NUM_PT-1:0] pt,
    input  mc_cfg_t           cfg,
    output logic              dout
);
    localparam int BASE = IDX * PT_PER_MC;

    logic short_sum;
    logic wide_sum;
    logic sum;
    logic q;

    assign short_sum = |pt[BASE +: PT_PER_MC];
    assign wide_sum  = (|(pt & cfg.or_mask)) ^ (cfg.xor_en & pt[BASE]);
    assign sum       = cfg.bypass ? short_sum : wide_sum;

    always_ff @(posedge blk_clk or posedge clr) begin
        if (clr) q <= 1'b0;
        else     q <= sum;
    end

    assign dout = cfg.registered ? q : sum;
endmodule

// File: rtl/glb_logic_block.sv
`timescale 1ns/1ps
module glb_logic_block
    import glb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [ROW_W-1:0]    cfg_wdata,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                gclr_n,
    input  logic [NUM_IN-1:0]   din,
    output logic [NUM_MC-1:0]   dout,
    output logic [NUM_MC-1:0]   dout_oe
);
    pt_row_t                rows   [NUM_PT_ROWS];
    mc_cfg_t                mc_cfg [NUM_MC];
    blk_cfg_t               blk_cfg;
    logic [NUM_PT_ROWS-1:0] pt;
    logic                   blk_clk;
    logic                   clr;
    logic [NUM_MC-1:0]      reg_mask;

    glb_cfg_store u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rows    (rows),
        .mc_cfg  (mc_cfg),
        .blk_cfg (blk_cfg)
    );

    glb_and_plane u_plane (
        .din  (din),
        .rows (rows),
        .pt   (pt)
    );

    always_comb begin
        case (blk_cfg.clk_sel)
            CK_G0:   blk_clk = gclk[0];
            CK_G1:   blk_clk = gclk[1];
            CK_G2:   blk_clk = gclk[2];
            default: blk_clk = pt[ROW_CLK];
        endcase
    end

    assign clr     = !gclr_n || (blk_cfg.rst_pt_en && pt[ROW_RST]);
    assign dout_oe = blk_cfg.oe_pt_en ? {NUM_MC{pt[ROW_OE]}} : '1;

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        glb_macrocell #(.IDX(m)) u_mc (
            .blk_clk (blk_clk),
            .clr     (clr),
            .pt      (pt[NUM_PT-1:0]),
            .cfg     (mc_cfg[m]),
            .dout    (dout[m])
        );
        assign reg_mask[m] = mc_cfg[m].registered;
    end

    AST_GCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !gclr_n |-> ((dout & reg_mask) == '0)) else $error("global clear ignored"); // R6

    AST_PTRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (blk_cfg.rst_pt_en && pt[ROW_RST]) |-> ((dout & reg_mask) == '0)) else $error("reset term ignored"); // R7
endmodule

// File: tb/tb_glb_logic_block.sv
`timescale 1ns/1ps
module tb_glb_logic_block;
    import glb_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_we = 1'b0;
    logic [ADDR_W-1:0]   cfg_addr = '0;
    logic [ROW_W-1:0]    cfg_wdata = '0;
    logic [NUM_GCLK-1:0] gclk = '0;
    logic                gclr_n = 1'b0;
    logic [NUM_IN-1:0]   din_drv = '0;
    logic                fb_mode = 1'b0;
    logic [NUM_IN-1:0]   din;
    logic [NUM_MC-1:0]   dout;
    logic [NUM_MC-1:0]   dout_oe;
    int n_chk = 0;
    int n_err = 0;
    logic [3:0] cnt;

    always #2 clk = ~clk;

    assign din = fb_mode ? {din_drv[NUM_IN-1:NUM_MC], dout} : din_drv;

    glb_logic_block dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .gclk(gclk), .gclr_n(gclr_n),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ROW_W-1:0] lit_t(input int b);
        return ROW_W'(1) << b;
    endfunction
    function automatic logic [ROW_W-1:0] lit_c(input int b);
        return ROW_W'(1) << (NUM_IN + b);
    endfunction

    task automatic cfg_write(input int a, input logic [ROW_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; gclr_n = 1'b0; fb_mode = 1'b0; din_drv = '0; gclk = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0; gclr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_g(input int k);
        #1 gclk[k] = 1'b1;
        #2 gclk[k] = 1'b0;
        #2;
    endtask

    task automatic pulse_pt();
        #1 din_drv[17] = 1'b1;
        #2 din_drv[17] = 1'b0;
        #2;
    endtask

    task automatic blk_word(input int sel, input bit rst_en, input bit oe_en);
        cfg_write(ADDR_BLK, ROW_W'(sel) | (ROW_W'(rst_en) << 2) | (ROW_W'(oe_en) << 3));
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check("R9 reset dout", dout, 4'h0);
        check("R9 reset oe", dout_oe, 4'hF);
    endtask

    task automatic t_decoder();
        logic [ROW_W-1:0] r0;
        logic [ROW_W-1:0] bad;
        logic [NUM_IN-1:0] pats [4];
        do_reset();
        r0 = '0;
        for (int b = 0; b < 8; b++)
            r0 |= ((8'hA5 >> b) & 1) != 0 ? lit_t(10 + b) : lit_c(10 + b);
        bad = lit_t(0) | lit_c(0);
        cfg_write(0, r0); cfg_write(1, bad); cfg_write(2, bad); cfg_write(3, bad);
        cfg_write(4, bad); cfg_write(5, lit_t(9) | lit_c(8)); cfg_write(6, bad); cfg_write(7, bad);
        for (int m = 0; m < 3; m++) cfg_write(ADDR_MC0 + m, ROW_W'(1) << 21);
        pats[0] = {8'hA5, 2'b10, 8'h00};
        pats[1] = {8'hA4, 2'b10, 8'hFF};
        pats[2] = {8'hA5, 2'b11, 8'h01};
        pats[3] = {8'h5A, 2'b01, 8'h7E};
        for (int p = 0; p < 4; p++) begin
            logic [3:0] e;
            din_drv = pats[p];
            #1;
            e[0] = (pats[p][17:10] == 8'hA5);
            e[1] = pats[p][9] & ~pats[p][8];
            e[2] = 1'b1;
            e[3] = 1'b0;
            check("R1 R2 R4 decode bypass/comb", dout, e);
        end
        // wide path, combinational, mask picks term 5 only
        cfg_write(ADDR_MC0 + 3, ROW_W'(1) << 5);
        din_drv = {8'h00, 2'b10, 8'h00};
        #1 check("R3 wide mask", dout[3:2], 2'b11);
        din_drv = {8'h00, 2'b00, 8'h00};
        #1 check("R3 wide mask off", dout[3:2], 2'b01);
    endtask

    task automatic t_oe();
        cfg_write(ROW_OE, lit_t(15));
        blk_word(0, 1'b0, 1'b1);
        din_drv = '0; din_drv[15] = 1'b1;
        #1 check("R8 oe term high", dout_oe, 4'hF);
        din_drv[15] = 1'b0;
        #1 check("R8 oe term low", dout_oe, 4'h0);
        blk_word(0, 1'b0, 1'b0);
        #1 check("R8 oe term disabled", dout_oe, 4'hF);
    endtask

    task automatic prog_counter();
        do_reset();
        for (int k = 0; k < NUM_MC; k++) begin
            logic [ROW_W-1:0] carry;
            carry = '0;
            for (int j = 0; j < k; j++) carry |= lit_t(j);
            cfg_write(4 * k, lit_t(k));
            cfg_write(4 * k + 1, carry);
            cfg_write(ADDR_MC0 + k, (ROW_W'(1) << 22) | (ROW_W'(1) << 20) | (ROW_W'(1) << (4 * k + 1)));
        end
        fb_mode = 1'b1;
        cnt = 4'h0;
        #1 check("R4 counter start", dout, cnt);
    endtask

    task automatic t_counter();
        prog_counter();
        for (int i = 0; i < 18; i++) begin
            pulse_g(0);
            cnt = cnt + 4'h1;
            check("R3 R4 counter step", dout, cnt);
        end
        pulse_g(1); pulse_g(2);
        check("R5 unselected clocks", dout, cnt);
        // hold: address/data for the block word with strobe low
        @(negedge clk);
        cfg_addr = ADDR_W'(ADDR_BLK); cfg_wdata = '1;
        repeat (3) @(negedge clk);
        cfg_wdata = '0;
        pulse_g(0); cnt = cnt + 4'h1;
        check("R10 no write without strobe", dout, cnt);
    endtask

    task automatic t_clk_select();
        prog_counter();
        blk_word(1, 1'b0, 1'b0);
        pulse_g(0);
        check("R5 g0 ignored when g1 picked", dout, cnt);
        pulse_g(1); cnt = cnt + 4'h1;
        check("R5 g1 selected", dout, cnt);
        blk_word(2, 1'b0, 1'b0);
        pulse_g(2); cnt = cnt + 4'h1;
        pulse_g(1);
        check("R5 g2 selected", dout, cnt);
        cfg_write(ROW_CLK, lit_t(17));
        blk_word(3, 1'b0, 1'b0);
        #1 check("R4 hold across select change", dout, cnt);
        pulse_pt(); cnt = cnt + 4'h1;
        pulse_pt(); cnt = cnt + 4'h1;
        pulse_g(0); pulse_g(2);
        check("R5 term clock", dout, cnt);
    endtask

    task automatic t_clear_prio();
        prog_counter();
        repeat (5) begin pulse_g(0); cnt = cnt + 4'h1; end
        check("R6 pre-clear count", dout, 4'h5);
        gclr_n = 1'b0;
        #1 check("R6 async clear", dout, 4'h0);
        pulse_g(0); pulse_g(0);
        check("R6 clear beats clock", dout, 4'h0);
        gclr_n = 1'b1;
        pulse_g(0);
        check("R6 resume after clear", dout, 4'h1);
        // reset term
        cfg_write(ROW_RST, lit_t(16));
        blk_word(0, 1'b1, 1'b0);
        pulse_g(0); pulse_g(0);
        check("R7 count before term reset", dout, 4'h3);
        din_drv[16] = 1'b1;
        #1 check("R7 term reset async", dout, 4'h0);
        pulse_g(0);
        check("R7 term reset beats clock", dout, 4'h0);
        din_drv[16] = 1'b0;
        pulse_g(0);
        check("R7 resume after term reset", dout, 4'h1);
        blk_word(0, 1'b0, 1'b0);
        din_drv[16] = 1'b1;
        pulse_g(0);
        check("R7 term reset disabled", dout, 4'h2);
        din_drv[16] = 1'b0;
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset_state();
        t_decoder();
        t_oe();
        t_counter();
        t_clk_select();
        t_clear_prio();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule